// File: doc/BRIEF.md
# SDRAM power-up initialization sequencer

This block brings an SDRAM from power-on to an operational state. It drives the device command pins, CKE, the address bus and the bank select, and it has no other inputs than clock and reset. After reset is released it keeps the bus quiet with NOP commands for the power-up delay. It then precharges all banks, issues two auto-refresh commands and programs the mode register. The mode word is built from elaboration parameters. After a final settling wait, a ready flag rises and stays high. From then on a controller can take over the bus.

All waits are counted in clock cycles. The power-up delay is the product of a clock-frequency parameter in MHz and a delay parameter in microseconds. The gaps after precharge, after each refresh and after the mode load are separate parameters, each of at least 2. The gap cycles between commands are filled with NOP.

Elaboration fails for any of these settings:
- a CAS latency other than 2 or 3;
- a burst length outside 1, 2, 4 and 8 when the full-page burst is not selected;
- full page combined with interleaved ordering;
- a gap parameter below 2;
- an address bus narrower than 11 bits.

There is no data stream: every pin is a plain control or status signal with no handshake.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the command pins show INHIBIT ({cs_n,ras_n,cas_n,we_n}=1111) and init_done is 0. After release, NOP (0111) is shown for exactly P = CLK_MHZ*PWRUP_US cycles, counted from the first rising edge with reset high. P is at least one cycle.
- R2: cke is 1 in every cycle, in reset and after it.
- R3: The first command other than NOP is PRECHARGE (0010), shown P cycles after release, with addr bit 10 = 1, all other addr bits 0 and ba = 0.
- R4: Exactly two AUTO REFRESH commands (0001) follow. The first comes T_RP cycles after the precharge and the second T_RFC cycles after the first. addr and ba are 0 for both.
- R5: LOAD MODE (0000) comes T_RFC cycles after the second refresh, once only, with ba = 0.
- R6: During LOAD MODE, addr carries the mode word:
  - [2:0] is the burst length code (000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page);
  - [3] is 1 for interleaved ordering;
  - [6:4] is the CAS latency (010 = 2, 011 = 3);
  - [8:7] is 00;
  - [9] is 1 for single-location writes;
  - every bit from 10 up is 0.
- R7: All cycles between the commands are NOP. init_done rises exactly T_MRD cycles after LOAD MODE and then stays 1 until reset.
- R8: While init_done is 1, only NOP is shown, with addr and ba at 0.
- R9: Asserting reset at any point, including mid-sequence, returns the pins to INHIBIT at once. The next release restarts the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the SDRAM, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ROW_W | Address bus; bit 10 selects all banks on precharge; mode word on load |
| ba | output | BANK_W | Bank select, 0 throughout |
| init_done | output | 1 | High once initialization is complete |

## Verification
All outputs are registered. The command decided at rising edge n is on the pins from that edge until the next one. Taking edge 0 as the first edge with reset high, the timing is:
- NOP for edges 0 to P-1;
- PRECHARGE at edge P;
- refreshes at P+T_RP and P+T_RP+T_RFC;
- LOAD MODE at P+T_RP+2*T_RFC;
- init_done from T_MRD edges after that.

The bench counts edges from each release and computes the expected pins for edge n from these offsets alone. It samples on the falling edge after edge n. Reset is checked half a cycle after it is asserted, because it acts asynchronously. The bench aborts runs with reset at random edges, so that restarts from every phase are seen.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'b1111,
    CMD_NOP     = 4'b0111,
    CMD_PRE     = 4'b0010,
    CMD_REF     = 4'b0001,
    CMD_LMR     = 4'b0000
  } sdram_cmd_e;

  // bit of the address bus that selects all banks on precharge
  localparam int ALL_BANK_BIT = 10;
  // width of the defined part of the mode word
  localparam int MODE_W = 10;

  function automatic logic [2:0] burst_code(int len, bit full);
    if (full) return 3'b111;
    case (len)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] pack_mode(int len, bit full, bit ilv, int cl, bit single);
    logic [MODE_W-1:0] w;
    w      = '0;
    w[2:0] = burst_code(len, full);
    w[3]   = ilv;
    w[6:4] = 3'(cl);
    w[8:7] = 2'b00;
    w[9]   = single;
    return w;
  endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(INIT);
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // a running count steps down by exactly one per cycle
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R7

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int ROW_W            = 13,
  parameter int BURST_LEN        = 4,
  parameter int BURST_FULL       = 0,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT          = 3,
  parameter int WRITE_SINGLE     = 0
) (
  output logic [ROW_W-1:0] word
);

  localparam int PAD_W = ROW_W - MODE_W;

  if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cl
    $error("sdram_mode_word: CAS latency must be 2 or 3");
  end
  if (BURST_FULL == 0 && !(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
    $error("sdram_mode_word: burst length must be 1, 2, 4 or 8");
  end
  if (BURST_FULL != 0 && BURST_INTERLEAVE != 0) begin : g_bad_fp
    $error("sdram_mode_word: full page requires sequential ordering");
  end

  assign word = {{PAD_W{1'b0}},
                 pack_mode(BURST_LEN, BURST_FULL != 0, BURST_INTERLEAVE != 0,
                           CAS_LAT, WRITE_SINGLE != 0)};

endmodule

// File: rtl/sdram_cmd_drv.sv
module sdram_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdram_cmd_e        cmd_nxt,
  input  logic [ROW_W-1:0]  addr_nxt,
  input  logic              done_nxt,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_INHIBIT;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
      cke       <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_nxt;
      addr      <= addr_nxt;
      ba        <= '0;
      init_done <= done_nxt;
      cke       <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ROW_W            = 13,
  parameter int BANK_W           = 2,
  parameter int CLK_MHZ          = 100,
  parameter int PWRUP_US         = 100,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 9,
  parameter int T_MRD            = 2,
  parameter int BURST_LEN        = 4,
  parameter int BURST_FULL       = 0,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT          = 3,
  parameter int WRITE_SINGLE     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);

  localparam int PWR_CYC  = CLK_MHZ * PWRUP_US;
  localparam int GAP_MAX  = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                           : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int TMR_MAX  = (PWR_CYC > GAP_MAX) ? PWR_CYC : GAP_MAX;
  localparam int TW       = $clog2(TMR_MAX + 1);
  localparam int GW       = $clog2(GAP_MAX + 2);

  if (PWR_CYC < 1) begin : g_bad_pwr
    $error("sdram_init_seq: power-up wait must be at least one cycle");
  end
  if (T_RP < 2 || T_RFC < 2 || T_MRD < 2) begin : g_bad_gap
    $error("sdram_init_seq: command gaps must be at least 2 cycles");
  end
  if (ROW_W <= ALL_BANK_BIT) begin : g_bad_row
    $error("sdram_init_seq: address bus too narrow");
  end

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE, ST_RP, ST_REF1, ST_RFC1, ST_REF2, ST_RFC2, ST_LMR, ST_MRD, ST_DONE
  } seq_st_e;

  seq_st_e          st, st_nxt;
  sdram_cmd_e       cmd_nxt;
  logic [ROW_W-1:0] addr_nxt;
  logic [ROW_W-1:0] mode_word;
  logic             done_nxt;
  logic             tmr_ld;
  logic [TW-1:0]    tmr_val;
  logic             tmr_zero;

  sdram_mode_word #(
    .ROW_W(ROW_W), .BURST_LEN(BURST_LEN), .BURST_FULL(BURST_FULL),
    .BURST_INTERLEAVE(BURST_INTERLEAVE), .CAS_LAT(CAS_LAT), .WRITE_SINGLE(WRITE_SINGLE)
  ) u_mode (
    .word(mode_word)
  );

  sdram_wait_timer #(.W(TW), .INIT(PWR_CYC - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    st_nxt   = st;
    cmd_nxt  = CMD_NOP;
    addr_nxt = '0;
    done_nxt = 1'b0;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_PWR:  if (tmr_zero) st_nxt = ST_PRE;
      ST_PRE: begin
        cmd_nxt                = CMD_PRE;
        addr_nxt[ALL_BANK_BIT] = 1'b1;
        tmr_ld                 = 1'b1;
        tmr_val                = TW'(T_RP - 2);
        st_nxt                 = ST_RP;
      end
      ST_RP:   if (tmr_zero) st_nxt = ST_REF1;
      ST_REF1: begin
        cmd_nxt = CMD_REF;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RFC - 2);
        st_nxt  = ST_RFC1;
      end
      ST_RFC1: if (tmr_zero) st_nxt = ST_REF2;
      ST_REF2: begin
        cmd_nxt = CMD_REF;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RFC - 2);
        st_nxt  = ST_RFC2;
      end
      ST_RFC2: if (tmr_zero) st_nxt = ST_LMR;
      ST_LMR: begin
        cmd_nxt  = CMD_LMR;
        addr_nxt = mode_word;
        tmr_ld   = 1'b1;
        tmr_val  = TW'(T_MRD - 2);
        st_nxt   = ST_MRD;
      end
      ST_MRD:  if (tmr_zero) st_nxt = ST_DONE;
      default: done_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PWR;
    else        st <= st_nxt;
  end

  sdram_cmd_drv #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .cmd_nxt(cmd_nxt), .addr_nxt(addr_nxt), .done_nxt(done_nxt),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done)
  );

  // ---------------- ordering checker on the pins ----------------
  logic [3:0]    pins;
  logic          is_cmd;
  logic          pre_seen, lmr_seen;
  logic [1:0]    ref_seen;
  logic [GW-1:0] gap, need;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_cmd = (pins != CMD_NOP) && (pins != CMD_INHIBIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen <= 1'b0;
      lmr_seen <= 1'b0;
      ref_seen <= '0;
      gap      <= '0;
      need     <= '0;
    end else begin
      if (is_cmd)                gap <= GW'(1);
      else if (gap != '1)        gap <= gap + 1'b1;
      if (pins == CMD_PRE) begin pre_seen <= 1'b1; need <= GW'(T_RP);  end
      if (pins == CMD_REF) begin ref_seen <= ref_seen + 1'b1; need <= GW'(T_RFC); end
      if (pins == CMD_LMR) begin lmr_seen <= 1'b1; need <= GW'(T_MRD); end
    end
  end

  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_PRE) |-> (!pre_seen && ref_seen == 2'd0 && !lmr_seen)); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_PRE) |-> addr[ALL_BANK_BIT]); // R3
  AST_REF_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_REF) |-> (pre_seen && ref_seen < 2'd2 && !lmr_seen)); // R4
  AST_LMR_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_LMR) |-> (ref_seen == 2'd2 && !lmr_seen)); // R5
  AST_LMR_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_LMR) |-> (addr[ROW_W-1:ALL_BANK_BIT] == '0)); // R6
  AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && pre_seen) |-> (gap >= need)); // R7
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (lmr_seen && gap == GW'(T_MRD))); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pins == CMD_NOP)); // R8

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 13;
  localparam int BANK_W = 2;
  localparam int CLK_MHZ = 10;
  localparam int PWRUP_US = 100;
  localparam int T_RP = 3;
  localparam int T_RFC = 7;
  localparam int T_MRD = 2;
  localparam int BL = 8;
  localparam int ILV = 1;
  localparam int CL = 2;
  localparam int WSINGLE = 1;

  localparam int P  = CLK_MHZ * PWRUP_US;
  localparam int E0 = P;
  localparam int E1 = E0 + T_RP;
  localparam int E2 = E1 + T_RFC;
  localparam int E3 = E2 + T_RFC;
  localparam int ED = E3 + T_MRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [ROW_W-1:0]  addr;
  logic [BANK_W-1:0] ba;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .BURST_LEN(BL), .BURST_FULL(0),
    .BURST_INTERLEAVE(ILV), .CAS_LAT(CL), .WRITE_SINGLE(WSINGLE)
  ) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done)
  );

  // expected mode word from the R6 layout
  function automatic logic [ROW_W-1:0] exp_mode();
    logic [ROW_W-1:0] w;
    w      = '0;
    w[2:0] = (BL == 1) ? 3'b000 : (BL == 2) ? 3'b001 : (BL == 4) ? 3'b010 : 3'b011;
    w[3]   = (ILV != 0);
    w[6:4] = (CL == 2) ? 3'b010 : 3'b011;
    w[9]   = (WSINGLE != 0);
    return w;
  endfunction

  function automatic logic [3:0] exp_cmd(int n);
    if (n == E0) return 4'b0010;
    if (n == E1 || n == E2) return 4'b0001;
    if (n == E3) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [ROW_W-1:0] exp_addr(int n);
    logic [ROW_W-1:0] a;
    a = '0;
    if (n == E0) a[10] = 1'b1;
    if (n == E3) a = exp_mode();
    return a;
  endfunction

  function automatic string req_of(int n);
    if (n < E0) return "R1";
    if (n == E0) return "R3";
    if (n == E1 || n == E2) return "R4";
    if (n == E3) return "R6";
    if (n >= ED) return "R8";
    return "R7";
  endfunction

  task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(int n);
    string r;
    r = req_of(n);
    check_val((n == E3) ? "R5" : r, $sformatf("cmd at edge %0d", n),
              32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd(n)));
    check_val(r, $sformatf("addr at edge %0d", n), 32'(addr), 32'(exp_addr(n)));
    check_val((n == E3) ? "R5" : r, $sformatf("ba at edge %0d", n), 32'(ba), 32'd0);
    check_val("R7", $sformatf("init_done at edge %0d", n), 32'(init_done), 32'(n >= ED));
    check_val("R2", $sformatf("cke at edge %0d", n), 32'(cke), 32'd1);
  endtask

  task automatic check_reset(string req);
    check_val(req, "cmd in reset", 32'({cs_n, ras_n, cas_n, we_n}), 32'hF);
    check_val(req, "init_done in reset", 32'(init_done), 32'd0);
    check_val("R2", "cke in reset", 32'(cke), 32'd1);
  endtask

  // release reset, follow the sequence up to edge stop_at, then reset again
  task automatic run(int stop_at);
    int hold;
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n <= stop_at; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(n);
    end
    rst_n = 1'b0;
    #1;
    check_reset("R9");
    hold = int'($urandom_range(3, 1));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check_reset("R9");
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    check_reset("R1");
    // directed aborts: first edge, precharge, between refreshes, mode load
    run(0);
    run(E0);
    run(E1 + 2);
    run(E3);
    // random abort points across every phase
    for (int i = 0; i < 4; i++) run(int'($urandom_range(ED + 5, 0)));
    // full sequence, long past completion
    run(ED + 40);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule